// File: doc/BRIEF.md
# Serial Port Register Bank with Character Queues

This block is the bus-facing half of a serial port. A 32-bit word bus reaches four registers through it: a control word, a receive-character port, a transmit-character port and a status word. Behind the registers sit a transmit queue and a receive queue. A separate serial frame engine, not part of this block, takes characters from the transmit queue and delivers received characters into the receive queue through single-cycle strobes.

Software writes characters to the transmit port and reads them from the receive port. It follows queue state through empty, full and fill-level bits, and it learns of events through sticky error flags and two interrupt-pending bits, which are combined onto one interrupt line. Writing a 1 to a pending or error bit in the status word clears that bit. A single six-bit level field reports either queue's fill count, and a control bit picks which queue it shows.

Top module: `sio_regbank`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x0000_0420 (bit 5 receive-empty and bit 10 transmit-empty set, all else clear), and `irq` is low.
- R2: A write to offset 0x000 stores bits 20:0 of the data word, and reading that offset returns them; bits 31:21 always read 0.
- R3: Each write to offset 0x008 queues bits 7:0. While control bit 15 (enable) is set and the queue holds data, `tx_avail` is high, `tx_char` shows the oldest character, and each `tx_pop` strobe removes it, so characters leave in write order. While enable is clear, `tx_avail` stays low.
- R4: Status bit 6 is set while the transmit queue holds TX_DEPTH characters. A write to offset 0x008 in that state is discarded and sets status bit 3.
- R5: A read of offset 0x004 removes the oldest received character and returns it in bits 7:0, with bits 31:8 zero. A read while the receive queue is empty returns 0 and leaves status bit 5 set.
- R6: An `rx_push` while the receive queue is full is discarded and sets status bit 2.
- R7: An accepted `rx_push` with `rx_err` high stores the character and sets status bit 4.
- R8: Writing 1 to status bit 2, 3 or 4 clears that flag. Writing 0 to it leaves it unchanged.
- R9: Status bits 16:11 report the transmit queue count when control bit 14 is 1, and the receive queue count when it is 0.
- R10: Status bit 0 becomes set when the receive queue is not empty and control bit 18 is set. Status bit 1 becomes set when the transmit queue holds fewer than TX_DEPTH/2 characters and control bit 19 is set. `irq` is high exactly when bit 0 or bit 1 is set.
- R11: A pending bit stays set after its condition goes away, until a 1 is written to it. A write of 1 while the condition still holds leaves it set.
- R12: Status bit 17 shows the `tx_busy` input as it was on the read cycle.
- R13: While enable is clear, `rx_push` is ignored and the receive queue is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid after the read cycle and held until the next read |
| irq | output | 1 | Interrupt request, OR of the two pending bits |
| ctl_word | output | 32 | Current control word, passed to the frame engine |
| tx_char | output | 8 | Oldest character in the transmit queue |
| tx_avail | output | 1 | Transmit character available to the engine |
| tx_pop | input | 1 | Engine takes `tx_char` |
| tx_busy | input | 1 | Engine is shifting a frame |
| rx_char | input | 8 | Character from the engine |
| rx_push | input | 1 | Engine delivers `rx_char` |
| rx_err | input | 1 | Delivered character had a frame or parity fault |

## Verification
The hardest cases to reach are the overflow cases. Each queue has to be filled to its exact depth with the engine side held still, and then given one more character. The bench holds its engine model in a stalled state while it writes TX_DEPTH+1 characters or pushes RX_DEPTH+1 characters. It then checks that the status flag is set, that the level field is pinned at the depth, and that only the first entries come back out of the scoreboard queue in order. The sticky pending bits take a similar sequence: the condition is raised, a clear is attempted while the condition holds, the condition is removed, and only then is the clear repeated.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W = 32;
  localparam int CHAR_W = 8;
  localparam int LVL_W  = 6;

  localparam logic [11:0] OFS_CTL = 12'h000;
  localparam logic [11:0] OFS_RXD = 12'h004;
  localparam logic [11:0] OFS_TXD = 12'h008;
  localparam logic [11:0] OFS_STA = 12'h00C;

  localparam logic [31:0] CTL_MASK = 32'h001F_FFFF;

  localparam int CB_LVLSEL = 14;
  localparam int CB_EN     = 15;
  localparam int CB_RXIE   = 18;
  localparam int CB_TXIE   = 19;

  // sticky status bit order inside the flag vector
  localparam int NFLAG  = 5;
  localparam int FL_PRX = 0;
  localparam int FL_PTX = 1;
  localparam int FL_OVR = 2;
  localparam int FL_TXE = 3;
  localparam int FL_FER = 4;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage array without reset so it maps onto RAM cells
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/sio_flags.sv
module sio_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag,
  output logic         irq
);
  logic [N-1:0] nxt;

  // set wins over a same-cycle clear
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign nxt[i] = set[i] | (flag[i] & ~clr[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= '0;
      irq  <= 1'b0;
    end else begin
      flag <= nxt;
      irq  <= nxt[sio_pkg::FL_PRX] | nxt[sio_pkg::FL_PTX];
    end
  end
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TCW     = $clog2(TX_DEPTH + 1),
  localparam int RCW     = $clog2(RX_DEPTH + 1),
  localparam int HALF    = TX_DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [31:0]       ctl_word,
  output logic [7:0]        tx_char,
  output logic              tx_avail,
  input  logic              tx_pop,
  input  logic              tx_busy,
  input  logic [7:0]        rx_char,
  input  logic              rx_push,
  input  logic              rx_err
);
  logic [31:0]      ctl_q;
  logic             hit_ctl, hit_rxd, hit_txd, hit_sta;
  logic             wr_ctl, wr_txd, wr_sta, rd_rxd, rd_sta;
  logic             en;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [TCW-1:0]   tx_cnt;
  logic [RCW-1:0]   rx_cnt;
  logic [7:0]       rx_head;
  logic             rx_take;
  logic [NFLAG-1:0] fl_set, fl_clr, fl_q;
  logic [LVL_W-1:0] level;
  logic [31:0]      sta_word, rd_mux;

  assign hit_ctl = (bus_addr == ADDR_W'(OFS_CTL));
  assign hit_rxd = (bus_addr == ADDR_W'(OFS_RXD));
  assign hit_txd = (bus_addr == ADDR_W'(OFS_TXD));
  assign hit_sta = (bus_addr == ADDR_W'(OFS_STA));
  assign wr_ctl  = bus_wr && hit_ctl;
  assign wr_txd  = bus_wr && hit_txd;
  assign wr_sta  = bus_wr && hit_sta;
  assign rd_rxd  = bus_rd && hit_rxd;
  assign rd_sta  = bus_rd && hit_sta;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (wr_ctl) ctl_q <= bus_wdata & CTL_MASK;
  end
  assign ctl_word = ctl_q;
  assign en       = ctl_q[CB_EN];

  sio_fifo #(.DEPTH(TX_DEPTH), .W(CHAR_W)) u_txq (
    .clk(clk), .rst(rst),
    .push(wr_txd), .pop(tx_pop && en),
    .din(bus_wdata[7:0]), .dout(tx_char),
    .full(tx_full), .empty(tx_empty), .count(tx_cnt)
  );
  assign tx_avail = en && !tx_empty;

  assign rx_take = rx_push && en;
  sio_fifo #(.DEPTH(RX_DEPTH), .W(CHAR_W)) u_rxq (
    .clk(clk), .rst(rst),
    .push(rx_take), .pop(rd_rxd),
    .din(rx_char), .dout(rx_head),
    .full(rx_full), .empty(rx_empty), .count(rx_cnt)
  );

  always_comb begin
    fl_set         = '0;
    fl_set[FL_PRX] = !rx_empty && ctl_q[CB_RXIE];
    fl_set[FL_PTX] = (int'(tx_cnt) < HALF) && ctl_q[CB_TXIE];
    fl_set[FL_OVR] = rx_take && rx_full;
    fl_set[FL_TXE] = wr_txd && tx_full;
    fl_set[FL_FER] = rx_take && !rx_full && rx_err;
    fl_clr         = wr_sta ? bus_wdata[NFLAG-1:0] : '0;
  end

  sio_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(fl_set), .clr(fl_clr), .flag(fl_q), .irq(irq)
  );

  assign level = ctl_q[CB_LVLSEL] ? LVL_W'(tx_cnt) : LVL_W'(rx_cnt);

  always_comb begin
    sta_word        = '0;
    sta_word[4:0]   = fl_q;
    sta_word[5]     = rx_empty;
    sta_word[6]     = tx_full;
    sta_word[10]    = tx_empty;
    sta_word[16:11] = level;
    sta_word[17]    = tx_busy;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctl)      rd_mux = ctl_q;
    else if (hit_rxd) rd_mux = rx_empty ? 32'h0 : {24'h0, rx_head};
    else if (hit_sta) rd_mux = sta_word;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sio_regbank_chk.sv
module sio_regbank_chk #(
  parameter int TX_DEPTH = 16,
  parameter int TCW      = 5,
  parameter int RCW      = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_txd,
  input logic           tx_full,
  input logic [TCW-1:0] tx_cnt,
  input logic           rx_push,
  input logic           en,
  input logic           rx_full,
  input logic           rx_empty,
  input logic [RCW-1:0] rx_cnt,
  input logic           rd_rxd,
  input logic           rd_sta,
  input logic           tx_busy,
  input logic [4:0]     fl_q,
  input logic [31:0]    bus_rdata
);
  p_txdrop_flag_r4: assert property (@(posedge clk) disable iff (rst)
    wr_txd && tx_full |=> fl_q[3]);
  p_tx_bound_r4: assert property (@(posedge clk) disable iff (rst)
    int'(tx_cnt) <= TX_DEPTH);
  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rd_rxd && rx_empty |=> bus_rdata == 32'h0);
  p_overrun_flag_r6: assert property (@(posedge clk) disable iff (rst)
    rx_push && en && rx_full |=> fl_q[2]);
  p_busy_bit_r12: assert property (@(posedge clk) disable iff (rst)
    rd_sta |=> bus_rdata[17] == $past(tx_busy));
  p_off_ignores_rx_r13: assert property (@(posedge clk) disable iff (rst)
    rx_push && !en && !rd_rxd |=> $stable(rx_cnt));
endmodule

bind sio_regbank sio_regbank_chk #(.TX_DEPTH(TX_DEPTH), .TCW(TCW), .RCW(RCW)) u_chk (
  .clk(clk), .rst(rst), .wr_txd(wr_txd), .tx_full(tx_full), .tx_cnt(tx_cnt),
  .rx_push(rx_push), .en(en), .rx_full(rx_full), .rx_empty(rx_empty),
  .rx_cnt(rx_cnt), .rd_rxd(rd_rxd), .rd_sta(rd_sta), .tx_busy(tx_busy),
  .fl_q(fl_q), .bus_rdata(bus_rdata)
);

// File: tb/tb_sio_regbank.sv
module tb_sio_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 16;
  localparam int RXD = 16;
  localparam logic [11:0] A_CTL = 12'h000, A_RXD = 12'h004, A_TXD = 12'h008, A_STA = 12'h00C;
  localparam logic [31:0] EN = 32'h0000_8000;

  logic clk = 0, rst = 1;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata, ctl_word;
  logic irq, tx_avail, tx_pop = 0, tx_busy = 0, rx_push = 0, rx_err = 0;
  logic [7:0] tx_char, rx_char = '0;

  int n_run = 0, n_fail = 0;
  bit engine_go = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_regbank dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .ctl_word(ctl_word),
    .tx_char(tx_char), .tx_avail(tx_avail), .tx_pop(tx_pop), .tx_busy(tx_busy),
    .rx_char(rx_char), .rx_push(rx_push), .rx_err(rx_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rdr(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic send(input logic [7:0] c, input bit keep);
    wr(A_TXD, {24'h0, c});
    if (keep) txq.push_back(c);
  endtask

  task automatic deliver(input logic [7:0] c, input bit e, input bit keep);
    @(negedge clk); rx_char = c; rx_err = e; rx_push = 1;
    @(negedge clk); rx_push = 0; rx_err = 0;
    if (keep) rxq.push_back(c);
  endtask

  task automatic drain_tx();
    engine_go = 1;
    for (int i = 0; i < 200 && tx_avail; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    engine_go = 0;
    chk("R3 scoreboard emptied", txq.size(), 0);
  endtask

  // engine model and transmit monitor (scoreboard pop side)
  always @(negedge clk) begin
    if (engine_go && tx_avail) begin
      n_run++;
      if (txq.size() == 0) begin
        n_fail++; $display("FAIL R3 unexpected char actual=0x%02h expected=none", tx_char);
      end else begin
        logic [7:0] e;
        e = txq.pop_front();
        if (tx_char !== e) begin
          n_fail++; $display("FAIL R3 order actual=0x%02h expected=0x%02h", tx_char, e);
        end
      end
      tx_pop = 1;
    end else tx_pop = 0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst = 0;
    // R1
    chk("R1 irq", irq, 0);
    rdr(A_CTL, rd); chk("R1 ctl", rd, 0);
    rdr(A_STA, rd); chk("R1 status", rd, 32'h0000_0420);
    // R2
    wr(A_CTL, 32'hFFFF_FFFF); rdr(A_CTL, rd); chk("R2 ctl mask", rd, 32'h001F_FFFF);
    wr(A_CTL, EN); wr(A_STA, 32'h1F);
    rdr(A_STA, rd); chk("R2 status cleared", rd[4:0], 0);
    // R3 + R9 transmit level
    for (int i = 0; i < 5; i++) send(8'hA0 + 8'(i), 1);
    wr(A_CTL, EN | 32'h4000); rdr(A_STA, rd); chk("R9 tx level", rd[16:11], 5);
    wr(A_CTL, 32'h0); @(negedge clk); chk("R3 avail gated off", tx_avail, 0);
    wr(A_CTL, EN); @(negedge clk); chk("R3 avail on", tx_avail, 1);
    drain_tx();
    rdr(A_STA, rd); chk("R3 tx empty bit", rd[10], 1);
    // R12
    tx_busy = 1; rdr(A_STA, rd); chk("R12 busy high", rd[17], 1);
    tx_busy = 0; rdr(A_STA, rd); chk("R12 busy low", rd[17], 0);
    // R4 / R8
    for (int i = 0; i < TXD; i++) send(8'h10 + 8'(i), 1);
    rdr(A_STA, rd); chk("R4 full bit", rd[6], 1); chk("R4 no err yet", rd[3], 0);
    send(8'hEE, 0);
    wr(A_CTL, EN | 32'h4000);
    rdr(A_STA, rd); chk("R4 err bit", rd[3], 1); chk("R4 level pinned", rd[16:11], TXD);
    wr(A_STA, 32'h0); rdr(A_STA, rd); chk("R8 zero write keeps", rd[3], 1);
    wr(A_STA, 32'h8); rdr(A_STA, rd); chk("R8 w1c clears", rd[3], 0);
    wr(A_CTL, EN);
    drain_tx();
    // R5
    for (int i = 0; i < 3; i++) deliver(8'h5A + 8'(i), 0, 1);
    for (int i = 0; i < 3; i++) begin
      rdr(A_RXD, rd); chk("R5 rx data", rd, {24'h0, rxq.pop_front()});
    end
    rdr(A_RXD, rd); chk("R5 empty read", rd, 0);
    rdr(A_STA, rd); chk("R5 empty bit", rd[5], 1);
    // R13
    wr(A_CTL, 32'h0); deliver(8'h77, 0, 0);
    wr(A_CTL, EN); rdr(A_STA, rd); chk("R13 ignored", rd[5], 1);
    // R6 / R9 receive level
    for (int i = 0; i < RXD; i++) deliver(8'hC0 + 8'(i), 0, 1);
    rdr(A_STA, rd); chk("R6 no ovr yet", rd[2], 0);
    deliver(8'hFF, 0, 0);
    rdr(A_STA, rd); chk("R6 ovr bit", rd[2], 1); chk("R9 rx level", rd[16:11], RXD);
    for (int i = 0; i < RXD; i++) begin
      rdr(A_RXD, rd); chk("R6 kept data", rd, {24'h0, rxq.pop_front()});
    end
    wr(A_STA, 32'h4); rdr(A_STA, rd); chk("R8 ovr cleared", rd[2], 0);
    // R7
    deliver(8'h3C, 1, 1);
    rdr(A_STA, rd); chk("R7 fault bit", rd[4], 1);
    rdr(A_RXD, rd); chk("R7 char kept", rd, {24'h0, rxq.pop_front()});
    wr(A_STA, 32'h10);
    // R10 / R11 receive pending
    wr(A_CTL, EN | 32'h0004_0000); chk("R10 no irq idle", irq, 0);
    deliver(8'h42, 0, 1); repeat (2) @(negedge clk);
    chk("R10 irq rx", irq, 1);
    wr(A_STA, 32'h1); rdr(A_STA, rd); chk("R11 held while cond", rd[0], 1);
    rdr(A_RXD, rd); chk("R10 rx char", rd, {24'h0, rxq.pop_front()});
    repeat (2) @(negedge clk);
    rdr(A_STA, rd); chk("R11 sticky", rd[0], 1);
    wr(A_STA, 32'h1); @(negedge clk);
    rdr(A_STA, rd); chk("R11 cleared", rd[0], 0); chk("R10 irq low", irq, 0);
    // R10 / R11 transmit pending
    wr(A_CTL, EN | 32'h0008_0000); repeat (2) @(negedge clk);
    chk("R10 irq tx", irq, 1);
    for (int i = 0; i < TXD/2; i++) send(8'h60 + 8'(i), 1);
    wr(A_STA, 32'h2); @(negedge clk);
    rdr(A_STA, rd); chk("R11 tx cleared", rd[1], 0); chk("R10 irq tx low", irq, 0);
    wr(A_CTL, EN);
    drain_tx();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule